// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block sits in front of a small word-addressed memory that several requesters share. Besides plain loads and stores it serves a linked load, which returns a word and reserves that address for the requester, and a conditional store. The conditional store writes only when the requester's reservation is still intact, and it reports through a success flag whether it wrote. A requester builds a lock or any other atomic read-modify-write from these two operations. It reads with the linked load, tests the value, tries the conditional store and repeats the sequence until the store succeeds.

Requests arrive on one valid/ready port per requester. A round-robin arbiter grants at most one request per cycle, so every reservation check and memory update happens in a fixed order. Each requester holds one reservation, made of a valid bit and an address. The reservation is lost in four cases: another requester writes the same word, the requester tries a conditional store, the requester issues a new linked load, or the requester's context-switch input is raised.

Top module: `llsc_monitor`

## Requirements
- R1: Operation codes are 0 load, 1 store, 2 linked load and 3 conditional store. Every granted operation returns, on the granted requester's `rsp_rdata` slice, the value the addressed word held before that operation.
- R2: A linked load followed by a conditional store from the same requester to the same address, with nothing in between that clears the reservation, gives `rsp_ok`=1 and writes the store data to memory.
- R3: A failed conditional store gives `rsp_ok`=0 and leaves the addressed word unchanged.
- R4: A plain store or a successful conditional store from one requester clears the reservation of every other requester that holds the same address.
- R5: A conditional store to an address other than the reserved one fails.
- R6: Raising `ctx_switch[i]` clears requester i's reservation. If it is raised in the same cycle that requester i is granted a conditional store, that store fails. If it is raised in the same cycle as requester i's linked load, no reservation is kept.
- R7: A conditional store always clears its own requester's reservation, so a second one with no new linked load in between fails.
- R8: A new linked load replaces the requester's older reservation.
- R9: `req_ready` is one-hot or zero and only goes to a requester that is valid. The search starts at the requester after the one granted last, and requester 0 goes first after reset.
- R10: `rsp_valid` rises for exactly the granted requester in the cycle after the grant. `rsp_ok` is 0 for every operation other than a conditional store.
- R11: A plain store writes memory unconditionally.
- R12: After reset, every memory word reads 0, no requester holds a reservation, and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request valid, one per requester |
| req_ready | output | N_REQ | Grant, one-hot or zero |
| req_op | input | 2*N_REQ | Operation code per requester |
| req_addr | input | AW*N_REQ | Word address per requester |
| req_wdata | input | DW*N_REQ | Store data per requester |
| ctx_switch | input | N_REQ | Clears that requester's reservation |
| rsp_valid | output | N_REQ | Response valid, one cycle after grant |
| rsp_rdata | output | DW*N_REQ | Old word value per requester |
| rsp_ok | output | N_REQ | Conditional store succeeded |

## Verification
Two events can land in the same cycle. A reservation can be cleared, by a context switch or by another requester's write, in the cycle where the owner's conditional store is granted. The bench raises the context-switch input for a requester in the cycle its conditional store is granted, and also in the cycle its linked load is granted. It also raises all requesters' conditional stores together on one reserved word, so that the arbiter orders them back to back. Each result is judged against a bench model that follows the requirement text. In the all-requester case exactly one store may succeed, and the memory must hold that store's data.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int N_REQ = 3,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_REQ-1:0]    req_valid,
  output logic [N_REQ-1:0]    req_ready,
  input  logic [2*N_REQ-1:0]  req_op,
  input  logic [AW*N_REQ-1:0] req_addr,
  input  logic [DW*N_REQ-1:0] req_wdata,
  input  logic [N_REQ-1:0]    ctx_switch,
  output logic [N_REQ-1:0]    rsp_valid,
  output logic [DW*N_REQ-1:0] rsp_rdata,
  output logic [N_REQ-1:0]    rsp_ok
);
  localparam int DEPTH = 1 << AW;
  localparam int IW    = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_LL = 2'd2, OP_SC = 2'd3;

  logic [DW-1:0]    mem [DEPTH];
  logic [N_REQ-1:0] resv_v_q;
  logic [AW-1:0]    resv_a_q [N_REQ];
  logic [IW-1:0]    last_q, g_idx;
  logic             g_any;

  always_comb begin
    g_any = 1'b0;
    g_idx = last_q;
    for (int k = 1; k <= N_REQ; k++) begin
      int c;
      c = (int'(last_q) + k) % N_REQ;
      if (!g_any && req_valid[c]) begin
        g_any = 1'b1;
        g_idx = IW'(c);
      end
    end
  end

  assign req_ready = g_any ? (N_REQ'(1) << g_idx) : '0;

  logic [1:0]    g_op;
  logic [AW-1:0] g_addr;
  logic [DW-1:0] g_wdata, mem_rd;
  logic          sc_ok, wr_en;

  assign g_op    = req_op[2*g_idx +: 2];
  assign g_addr  = req_addr[AW*g_idx +: AW];
  assign g_wdata = req_wdata[DW*g_idx +: DW];
  assign mem_rd  = mem[g_addr];
  assign sc_ok   = g_any && (g_op == OP_SC) && resv_v_q[g_idx] &&
                   (resv_a_q[g_idx] == g_addr) && !ctx_switch[g_idx];
  assign wr_en   = g_any && ((g_op == OP_ST) || sc_ok);

  for (genvar i = 0; i < N_REQ; i++) begin : g_resv
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        resv_v_q[i] <= 1'b0;
        resv_a_q[i] <= '0;
      end else if (ctx_switch[i]) begin
        resv_v_q[i] <= 1'b0;
      end else if (g_any && g_idx == IW'(i)) begin
        if (g_op == OP_LL) begin
          resv_v_q[i] <= 1'b1;
          resv_a_q[i] <= g_addr;
        end else if (g_op == OP_SC) begin
          resv_v_q[i] <= 1'b0;
        end
      end else if (wr_en && resv_a_q[i] == g_addr) begin
        resv_v_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
    end else if (wr_en) begin
      mem[g_addr] <= g_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q    <= IW'(N_REQ - 1);
      rsp_valid <= '0;
      rsp_ok    <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_ready;
      rsp_ok    <= sc_ok ? req_ready : '0;
      if (g_any) begin
        last_q <= g_idx;
        rsp_rdata[DW*g_idx +: DW] <= mem_rd;
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R9
  AST_GRANT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0); // R9
  AST_OK_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ok & ~rsp_valid) == '0); // R10
  AST_SC_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (g_any && g_op == OP_SC && !sc_ok) |=> mem[$past(g_addr)] == $past(mem[g_addr])); // R3
  AST_CTX_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctx_switch) |=> ((resv_v_q & $past(ctx_switch)) == '0)); // R6
  AST_SC_DROPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (g_any && g_op == OP_SC) |=> !resv_v_q[$past(g_idx)]); // R7
endmodule

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
  localparam int N = 3, AW = 4, DW = 16;
  localparam logic [1:0] LD = 0, ST = 1, LL = 2, SC = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_valid = 0, req_ready, ctx_switch = 0, rsp_valid, rsp_ok;
  logic [2*N-1:0] req_op = 0;
  logic [AW*N-1:0] req_addr = 0;
  logic [DW*N-1:0] req_wdata = 0, rsp_rdata;

  llsc_monitor #(.N_REQ(N), .AW(AW), .DW(DW)) u_llsc_monitor (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_wdata,
    .ctx_switch, .rsp_valid, .rsp_rdata, .rsp_ok);

  always #10 clk = ~clk;

  int checks = 0, errs = 0, n_ok = 0;
  logic [DW-1:0] mm [1<<AW];
  logic rv [N];
  logic [AW-1:0] ra [N];
  int last = N - 1;
  logic [1:0] op_r [N];
  logic [AW-1:0] addr_r [N];
  logic [DW-1:0] wd_r [N];
  logic last_ok;

  task automatic chk(input logic c, input string tag, input longint act, input longint exp);
    checks++;
    if (!c) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] vm, input logic [N-1:0] cm, input string tag, output int gi);
    int g = -1;
    logic [N-1:0] er = 0;
    logic [DW-1:0] rd = 0;
    logic ok = 0;
    for (int i = 0; i < N; i++) begin
      req_op[2*i +: 2] = op_r[i];
      req_addr[AW*i +: AW] = addr_r[i];
      req_wdata[DW*i +: DW] = wd_r[i];
    end
    req_valid = vm;
    ctx_switch = cm;
    #1;
    for (int k = 1; k <= N; k++) if (g < 0 && vm[(last + k) % N]) g = (last + k) % N;
    if (g >= 0) er = N'(1) << g;
    chk(req_ready == er, "R9 grant", req_ready, er);
    if (g >= 0) begin
      logic [AW-1:0] a = addr_r[g];
      logic wr = 0;
      rd = mm[a];
      case (op_r[g])
        LL: begin rv[g] = 1; ra[g] = a; end
        ST: wr = 1;
        SC: begin
          ok = rv[g] && ra[g] == a && !cm[g];
          wr = ok;
          rv[g] = 0;
        end
        default: ;
      endcase
      if (wr) begin
        mm[a] = wd_r[g];
        for (int j = 0; j < N; j++) if (j != g && ra[j] == a) rv[j] = 0;
      end
      last = g;
    end
    for (int j = 0; j < N; j++) if (cm[j]) rv[j] = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    ctx_switch = 0;
    if (g >= 0) begin
      chk(rsp_valid == er, "R10 rsp_valid", rsp_valid, er);
      chk(rsp_rdata[DW*g +: DW] == rd, "R1 rdata", rsp_rdata[DW*g +: DW], rd);
      chk(rsp_ok == (ok ? er : '0), tag, rsp_ok, ok ? er : '0);
      if (ok) n_ok++;
    end
    last_ok = ok;
    gi = g;
  endtask

  task automatic one(input int r, input logic [1:0] op, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [N-1:0] cm, input string tag);
    int gi;
    op_r[r] = op; addr_r[r] = a; wd_r[r] = d;
    step(N'(1) << r, cm, tag, gi);
  endtask

  task automatic all(input logic [N-1:0] vm, input string tag);
    logic [N-1:0] p = vm;
    while (p != 0) begin
      int gi;
      step(p, 0, tag, gi);
      if (gi >= 0) p[gi] = 1'b0;
      else break;
    end
  endtask

  initial begin
    #(20ns * 150000);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mm[i] = 0;
    for (int i = 0; i < N; i++) begin
      rv[i] = 0; ra[i] = 0; op_r[i] = LD; addr_r[i] = 0; wd_r[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(rsp_valid == 0, "R12 no rsp", rsp_valid, 0);
    chk(req_ready == 0, "R12 idle", req_ready, 0);
    for (int a = 0; a < (1 << AW); a++) one(0, LD, AW'(a), 0, 0, "R12 zero");
    one(1, SC, 2, 16'h55, 0, "R12 no resv");
    chk(!last_ok, "R12 sc", last_ok, 0);

    for (int r = 0; r < N; r++)
      for (int a = 0; a < (1 << AW); a++) begin
        one(r, ST, AW'(a), DW'(r * 256 + a * 7 + 1), 0, "R11 store");
        one(r, LL, AW'(a), 0, 0, "R1 ll");
        one(r, SC, AW'(a), DW'(r * 512 + a * 3 + 9), 0, "R2 sc ok");
        chk(last_ok, "R2 sc ok", last_ok, 1);
        one(r, LD, AW'(a), 0, 0, "R2 readback");
      end

    one(0, LL, 5, 0, 0, "R4");
    one(1, ST, 5, 16'h1111, 0, "R4");
    one(0, SC, 5, 16'h2222, 0, "R4 killed by store");
    chk(!last_ok, "R4 store kill", last_ok, 0);
    one(0, LD, 5, 0, 0, "R3 unchanged");
    one(0, LL, 6, 0, 0, "R4");
    one(2, LL, 6, 0, 0, "R4");
    one(2, SC, 6, 16'h3333, 0, "R4 first sc");
    one(0, SC, 6, 16'h4444, 0, "R4 killed by sc");
    chk(!last_ok, "R4 sc kill", last_ok, 0);

    one(1, LL, 3, 0, 0, "R5");
    one(1, SC, 4, 16'h5555, 0, "R5 other addr");
    chk(!last_ok, "R5 other addr", last_ok, 0);
    one(1, LD, 4, 0, 0, "R3 unchanged");

    one(2, LL, 7, 0, 0, "R6");
    begin int gi; step(0, 3'b100, "R6", gi); end
    one(2, SC, 7, 16'h6666, 0, "R6 after ctx");
    chk(!last_ok, "R6 after ctx", last_ok, 0);
    one(2, LL, 7, 0, 0, "R6");
    one(2, SC, 7, 16'h7777, 3'b100, "R6 same cycle sc");
    chk(!last_ok, "R6 same cycle sc", last_ok, 0);
    one(2, LL, 7, 0, 3'b100, "R6 same cycle ll");
    one(2, SC, 7, 16'h8888, 0, "R6 ll lost");
    chk(!last_ok, "R6 ll lost", last_ok, 0);
    one(1, LL, 7, 0, 0, "R6");
    one(2, LD, 0, 0, 3'b100, "R6 other ctx");
    one(1, SC, 7, 16'h9999, 0, "R6 other keeps");
    chk(last_ok, "R6 other keeps", last_ok, 1);

    one(0, LL, 8, 0, 0, "R7");
    one(0, SC, 8, 16'hAAAA, 0, "R7 first");
    one(0, SC, 8, 16'hBBBB, 0, "R7 second");
    chk(!last_ok, "R7 second", last_ok, 0);

    one(1, LL, 9, 0, 0, "R8");
    one(1, LL, 10, 0, 0, "R8");
    one(1, SC, 9, 16'hCCCC, 0, "R8 old addr");
    chk(!last_ok, "R8 old addr", last_ok, 0);
    one(1, LL, 9, 0, 0, "R8");
    one(1, LL, 10, 0, 0, "R8");
    one(1, SC, 10, 16'hDDDD, 0, "R8 new addr");
    chk(last_ok, "R8 new addr", last_ok, 1);

    for (int i = 0; i < N; i++) begin op_r[i] = LL; addr_r[i] = 11; end
    all(3'b111, "R9 ll");
    n_ok = 0;
    for (int i = 0; i < N; i++) begin op_r[i] = SC; wd_r[i] = DW'(16'hE000 + i); end
    all(3'b111, "R9 race");
    chk(n_ok == 1, "R9 one winner", n_ok, 1);
    one(0, LD, 11, 0, 0, "R9 winner data");

    for (int rep = 0; rep < 4; rep++)
      for (int vm = 1; vm < (1 << N); vm++) begin
        for (int i = 0; i < N; i++) begin
          op_r[i] = 2'((vm + i + rep) % 4);
          addr_r[i] = AW'((vm * 3 + i) % 4);
          wd_r[i] = DW'(vm * 100 + i + rep);
        end
        all(N'(vm), "R10 mixed");
      end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule